// File: doc/BRIEF.md
# Per-Module Halt Clock-Gating Controller

This controller lets software stop the clocks of individual peripheral modules one at a time. A writable halt bit per module asks that module to stop. A module with shutdown logic receives a stop request and keeps its clock until it returns a stop acknowledge. A module without shutdown logic has its clock gated as soon as its halt bit is seen. Software reads the acknowledge state through read-only status words.

When a halt bit is cleared, the module's clock enable returns first. The stop request stays high for a programmable number of cycles and then drops. Clearing a halt bit while the module has not yet acknowledged cancels the halt. The clock never stops, and the request is released after the same delay.

A separate, purely combinational path gates the shared platform clock group while every CPU core reports a wait state. The clock comes back in the same cycle that any core leaves the wait state. Interrupt and configuration logic stay outside any gated group.

Top module: `halt_gate_ctrl`

## Requirements
- R1: After reset all halt bits read 0, every module clock enable is 1 and every stop request is 0.
- R2: A write to halt word 0 (wr_addr 0, modules 0..31) or word 1 (wr_addr 1, modules 32..63) updates the halt bits at the capturing edge. The stop request of each newly halted module rises after the following edge. Modules whose bits did not change are unaffected.
- R3: For a module with shutdown logic, the clock enable stays 1 until stop acknowledge is seen. The acknowledge is registered once. The clock enable falls after the second edge that follows the acknowledge becoming high.
- R4: For a module marked as having no shutdown logic (a 1 in NO_SHUT_MASK), the stop request rises and the clock enable falls together, one edge after the halt bit is set. Its acknowledge input is ignored.
- R5: Read addresses 2 and 3 return the acknowledge status of modules 0..31 and 32..63. For a shutdown-capable module the bit is the registered acknowledge input. For a no-shutdown module the bit is 1 while its clock is gated.
- R6: After a halt bit is cleared on a gated module, the clock enable returns one edge after the halt register update. The stop request stays 1 for exactly REL_DLY more cycles and then falls.
- R7: Clearing a halt bit before the module acknowledges cancels the halt. The clock enable never falls, and the stop request falls REL_DLY cycles after release begins.
- R8: A halt bit set during the release delay is held until the delay ends. The stop request is then 0 for one cycle before a new halt begins.
- R9: plat_clk_en is 0 exactly when every bit of core_wait is 1, with no register delay.
- R10: Writes to addresses 2 and 3 change no halt bit. Halt and status bits for module indices at or above NUM_MOD read 0.
- R11: Read addresses 0 and 1 return the current halt bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word select: 0,1 halt words; 2,3 read-only |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word select: 0,1 halt words; 2,3 acknowledge words |
| rd_data | output | 32 | Combinational read data |
| mod_stop_ack | input | NUM_MOD | Stop acknowledge from each module |
| mod_stop_req | output | NUM_MOD | Stop request to each module |
| mod_clk_en | output | NUM_MOD | Clock enable to each module's gate cell |
| core_wait | input | NUM_CORES | Wait-state flag from each core |
| plat_clk_en | output | 1 | Clock enable for the shared platform group |

## Verification
A channel stuck in the wrong state shows up at mod_clk_en or mod_stop_req within one or two cycles of the halt write or of the acknowledge. A gated clock during a pending handshake appears as an early fall of the enable. A miscounted release delay moves the falling edge of the stop request by whole cycles. A reference model of every channel is compared against both outputs and the read word on every cycle, so a single-cycle slip is reported in the cycle it happens.

// File: rtl/hcg_pkg.sv
package hcg_pkg;
   typedef enum logic [1:0] {
      CH_RUN  = 2'd0,
      CH_REQ  = 2'd1,
      CH_OFF  = 2'd2,
      CH_WAKE = 2'd3
   } ch_state_e;

   localparam int WORD_W   = 32;
   localparam int MAX_MODS = 64;
endpackage

// File: rtl/hcg_chan.sv
module hcg_chan
   import hcg_pkg::*;
#(
   parameter int REL_DLY      = 4,
   parameter bit HAS_SHUTDOWN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_i,
   input  logic ack_i,
   output logic stop_o,
   output logic clk_en_o,
   output logic ack_stat_o
);
   localparam int CW = $clog2(REL_DLY + 1);

   if (REL_DLY < 1) begin : g_bad_dly
      $error("hcg_chan: REL_DLY must be at least 1");
   end

   ch_state_e       st_q;
   logic [CW-1:0]   cnt_q;
   logic            ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= ack_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= CH_RUN;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            CH_RUN: begin
               if (halt_i) st_q <= HAS_SHUTDOWN ? CH_REQ : CH_OFF;
            end
            CH_REQ: begin
               if (!halt_i) begin
                  st_q  <= CH_WAKE;
                  cnt_q <= '0;
               end else if (ack_q) begin
                  st_q <= CH_OFF;
               end
            end
            CH_OFF: begin
               if (!halt_i) begin
                  st_q  <= CH_WAKE;
                  cnt_q <= '0;
               end
            end
            CH_WAKE: begin
               if (cnt_q == CW'(REL_DLY - 1)) st_q <= CH_RUN;
               else                           cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= CH_RUN;
         endcase
      end
   end

   assign stop_o     = (st_q != CH_RUN);
   assign clk_en_o   = (st_q != CH_OFF);
   assign ack_stat_o = HAS_SHUTDOWN ? ack_q : (st_q == CH_OFF);

   // R3: the enable only falls after a registered acknowledge (shutdown channels)
   p_gate_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_SHUTDOWN && $fell(clk_en_o)) |-> $past(ack_q));

   // R7: the enable never falls once the halt bit has been cleared
   p_no_gate_without_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en_o) |-> $past(halt_i));

   // R6: clock returns while the stop request is still held
   p_clk_before_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en_o) |-> stop_o);

   // R6: stop request only drops with the clock running
   p_release_with_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_o) |-> clk_en_o);
endmodule

// File: rtl/hcg_regs.sv
module hcg_regs
   import hcg_pkg::*;
#(
   parameter int NUM_MOD = 40
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [WORD_W-1:0]  wr_data,
   input  logic [1:0]         rd_addr,
   input  logic [NUM_MOD-1:0] ack_stat_i,
   output logic [NUM_MOD-1:0] halt_o,
   output logic [WORD_W-1:0]  rd_data
);
   logic [NUM_MOD-1:0]  halt_q;
   logic [MAX_MODS-1:0] halt_pad;
   logic [MAX_MODS-1:0] ack_pad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= '0;
      end else if (wr_en && !wr_addr[1]) begin
         for (int i = 0; i < NUM_MOD; i++) begin
            if (wr_addr[0] == ((i / WORD_W) == 1)) halt_q[i] <= wr_data[i % WORD_W];
         end
      end
   end

   always_comb begin
      halt_pad              = '0;
      halt_pad[NUM_MOD-1:0] = halt_q;
      ack_pad               = '0;
      ack_pad[NUM_MOD-1:0]  = ack_stat_i;
   end

   always_comb begin
      unique case (rd_addr)
         2'd0:    rd_data = halt_pad[WORD_W-1:0];
         2'd1:    rd_data = halt_pad[MAX_MODS-1:WORD_W];
         2'd2:    rd_data = ack_pad[WORD_W-1:0];
         default: rd_data = ack_pad[MAX_MODS-1:WORD_W];
      endcase
   end

   assign halt_o = halt_q;

   // R10: writes to the status words leave the halt bits untouched
   p_status_words_readonly_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[1]) |=> $stable(halt_q));
endmodule

// File: rtl/hcg_platform.sv
module hcg_platform #(
   parameter int NUM_CORES = 2
) (
   input  logic [NUM_CORES-1:0] core_wait_i,
   output logic                 plat_clk_en_o
);
   if (NUM_CORES < 1) begin : g_bad_cores
      $error("hcg_platform: NUM_CORES must be at least 1");
   end

   assign plat_clk_en_o = ~(&core_wait_i);

   // R9: a single running core keeps the platform group clocked
   always_comb begin
      a_core_active_keeps_clk_r9: assert (!(plat_clk_en_o == 1'b0 && core_wait_i != '1));
   end
endmodule

// File: rtl/halt_gate_ctrl.sv
module halt_gate_ctrl
   import hcg_pkg::*;
#(
   parameter int          NUM_MOD      = 40,
   parameter int          NUM_CORES    = 2,
   parameter int          REL_DLY      = 4,
   parameter logic [63:0] NO_SHUT_MASK = 64'h0000_0002_0000_0020
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_addr,
   input  logic [31:0]          wr_data,
   input  logic [1:0]           rd_addr,
   output logic [31:0]          rd_data,
   input  logic [NUM_MOD-1:0]   mod_stop_ack,
   output logic [NUM_MOD-1:0]   mod_stop_req,
   output logic [NUM_MOD-1:0]   mod_clk_en,
   input  logic [NUM_CORES-1:0] core_wait,
   output logic                 plat_clk_en
);
   if (NUM_MOD < 1 || NUM_MOD > MAX_MODS) begin : g_bad_mods
      $error("halt_gate_ctrl: NUM_MOD must lie in 1..64");
   end

   logic [NUM_MOD-1:0] halt_w;
   logic [NUM_MOD-1:0] ack_stat_w;

   hcg_regs #(.NUM_MOD(NUM_MOD)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .ack_stat_i (ack_stat_w),
      .halt_o     (halt_w),
      .rd_data    (rd_data)
   );

   for (genvar g = 0; g < NUM_MOD; g++) begin : g_chan
      hcg_chan #(
         .REL_DLY      (REL_DLY),
         .HAS_SHUTDOWN (!NO_SHUT_MASK[g])
      ) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .halt_i     (halt_w[g]),
         .ack_i      (mod_stop_ack[g]),
         .stop_o     (mod_stop_req[g]),
         .clk_en_o   (mod_clk_en[g]),
         .ack_stat_o (ack_stat_w[g])
      );
   end

   hcg_platform #(.NUM_CORES(NUM_CORES)) u_plat (
      .core_wait_i   (core_wait),
      .plat_clk_en_o (plat_clk_en)
   );

   // R2: a stop request rises only for a module whose halt bit was set
   p_req_follows_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|($rose(mod_stop_req) & ~$past(halt_w))) == 1'b0);
endmodule

// File: tb/sim_halt_gate_ctrl.sv
module sim_halt_gate_ctrl;
   localparam int          CLK_PERIOD = 10;
   localparam int          NM         = 40;
   localparam int          NC         = 2;
   localparam int          N          = 4;
   localparam logic [63:0] NOSHUT     = 64'h0000_0002_0000_0020;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [1:0]    rd_addr = '0;
   logic [31:0]   rd_data;
   logic [NM-1:0] ack = '0;
   logic [NM-1:0] stop;
   logic [NM-1:0] cen;
   logic [NC-1:0] cwait = '0;
   logic          pcen;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   halt_gate_ctrl #(.NUM_MOD(NM), .NUM_CORES(NC), .REL_DLY(N), .NO_SHUT_MASK(NOSHUT)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .mod_stop_ack(ack), .mod_stop_req(stop),
      .mod_clk_en(cen), .core_wait(cwait), .plat_clk_en(pcen)
   );

   // reference model: 0 run, 1 waiting for ack, 2 gated, 3 release delay
   logic [63:0] m_halt;
   logic [63:0] m_ackq;
   int          m_st  [64];
   int          m_cnt [64];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_halt <= '0;
         m_ackq <= '0;
         for (int i = 0; i < 64; i++) begin
            m_st[i]  <= 0;
            m_cnt[i] <= 0;
         end
      end else begin
         if (wr_en && wr_addr == 2'd0) m_halt[31:0]  <= wr_data;
         if (wr_en && wr_addr == 2'd1) m_halt[63:32] <= wr_data & ((64'd1 << (NM - 32)) - 1);
         for (int i = 0; i < NM; i++) begin
            m_ackq[i] <= ack[i];
            case (m_st[i])
               0: if (m_halt[i]) m_st[i] <= NOSHUT[i] ? 2 : 1;
               1: if (!m_halt[i]) begin m_st[i] <= 3; m_cnt[i] <= 0; end
                  else if (m_ackq[i]) m_st[i] <= 2;
               2: if (!m_halt[i]) begin m_st[i] <= 3; m_cnt[i] <= 0; end
               default: if (m_cnt[i] == N - 1) m_st[i] <= 0; else m_cnt[i] <= m_cnt[i] + 1;
            endcase
         end
      end
   end

   function automatic logic exp_clk(input int st);
      return st != 2;
   endfunction

   function automatic logic exp_stop(input int st);
      return st != 0;
   endfunction

   function automatic logic [31:0] exp_word(input logic [1:0] a);
      logic [63:0] s;
      s = '0;
      for (int i = 0; i < NM; i++) s[i] = NOSHUT[i] ? (m_st[i] == 2) : m_ackq[i];
      case (a)
         2'd0:    return m_halt[31:0];
         2'd1:    return m_halt[63:32];
         2'd2:    return s[31:0];
         default: return s[63:32];
      endcase
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 clk_en", 64'(cen), 64'((65'd1 << NM) - 1));
      check("R1 stop", 64'(stop), 64'd0);
      rd_addr = 2'd0; #1 check("R1 halt word0", 64'(rd_data), 64'd0);

      // R2 halt module 2 (shutdown capable)
      wr(2'd0, 32'h4);
      check("R2 stop before", 64'(stop[2]), 64'd0);
      @(negedge clk);
      check("R2 stop rises", 64'(stop), 64'h4);
      check("R2 clk kept", 64'(cen[2]), 64'd1);
      // R3 clock held while ack is low
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         check("R3 clk held", 64'(cen[2]), 64'd1);
      end
      ack[2] = 1'b1;
      @(negedge clk);
      check("R3 clk after sample", 64'(cen[2]), 64'd1);
      @(negedge clk);
      check("R3 clk gated", 64'(cen[2]), 64'd0);
      rd_addr = 2'd2; #1 check("R5 ack status", 64'(rd_data[2]), 64'd1);
      // R6 release sequence
      wr(2'd0, 32'h0);
      check("R6 still gated", 64'(cen[2]), 64'd0);
      @(negedge clk);
      check("R6 clk back", 64'(cen[2]), 64'd1);
      check("R6 stop held", 64'(stop[2]), 64'd1);
      for (int j = 1; j < N; j++) begin
         @(negedge clk);
         check("R6 stop held", 64'(stop[2]), 64'd1);
      end
      @(negedge clk);
      check("R6 stop dropped", 64'(stop[2]), 64'd0);
      ack[2] = 1'b0;
      @(negedge clk);

      // R4 no-shutdown module 5, ack input held high to be ignored
      ack[5] = 1'b1;
      wr(2'd0, 32'h20);
      check("R4 clk before", 64'(cen[5]), 64'd1);
      @(negedge clk);
      check("R4 clk gated", 64'(cen[5]), 64'd0);
      check("R4 stop", 64'(stop[5]), 64'd1);
      rd_addr = 2'd2; #1 check("R5 noshut status", 64'(rd_data[5]), 64'd1);
      ack[5] = 1'b0;
      // R8 halt re-set during the release delay
      wr(2'd0, 32'h0);
      wr(2'd0, 32'h20);
      check("R8 wake clk", 64'(cen[5]), 64'd1);
      check("R8 wake stop", 64'(stop[5]), 64'd1);
      for (int j = 1; j < N; j++) begin
         @(negedge clk);
         check("R8 stop held", 64'(stop[5]), 64'd1);
      end
      @(negedge clk);
      check("R8 stop gap", 64'(stop[5]), 64'd0);
      @(negedge clk);
      check("R8 new halt", 64'(stop[5]), 64'd1);
      check("R8 new gate", 64'(cen[5]), 64'd0);
      wr(2'd0, 32'h0);
      repeat (N + 3) @(negedge clk);

      // R7 cancel before ack on module 2
      wr(2'd0, 32'h4);
      @(negedge clk);
      wr(2'd0, 32'h0);
      for (int j = 0; j < N; j++) begin
         @(negedge clk);
         check("R7 clk never off", 64'(cen[2]), 64'd1);
         check("R7 stop held", 64'(stop[2]), 64'd1);
      end
      @(negedge clk);
      check("R7 stop dropped", 64'(stop[2]), 64'd0);

      // R10, R11 register behaviour
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd2, 32'hFFFF_FFFF);
      wr(2'd3, 32'hFFFF_FFFF);
      rd_addr = 2'd1; #1 check("R10 R11 upper word", 64'(rd_data), 64'h0000_00FF);
      rd_addr = 2'd0; #1 check("R10 word0 untouched", 64'(rd_data), 64'd0);
      wr(2'd0, 32'hA5A5_0000);
      rd_addr = 2'd0; #1 check("R11 readback", 64'(rd_data), 64'hA5A5_0000);
      wr(2'd0, 32'h0);
      wr(2'd1, 32'h0);
      repeat (N + 3) @(negedge clk);

      // R9 platform gating
      cwait = 2'b11; #1 check("R9 all wait", 64'(pcen), 64'd0);
      cwait = 2'b01; #1 check("R9 one awake", 64'(pcen), 64'd1);
      cwait = 2'b00; #1 check("R9 none wait", 64'(pcen), 64'd1);

      // random phase against the model (R2 R3 R4 R5 R6 R7 R8 R9)
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         for (int i = 0; i < NM; i++) begin
            check("R3/R4/R6/R7/R8 clk_en", 64'(cen[i]), 64'(exp_clk(m_st[i])));
            check("R2/R6/R7/R8 stop", 64'(stop[i]), 64'(exp_stop(m_st[i])));
         end
         check("R5/R11 read", 64'(rd_data), 64'(exp_word(rd_addr)));
         check("R9 platform", 64'(pcen), 64'(!(&cwait)));
         wr_en   = (($urandom % 6) == 0);
         wr_addr = 2'($urandom % 4);
         wr_data = $urandom;
         rd_addr = 2'($urandom % 4);
         cwait   = NC'($urandom);
         for (int i = 0; i < NM; i++) begin
            if (NOSHUT[i])     ack[i] = 1'b0;
            else if (!stop[i]) ack[i] = 1'b0;
            else if (!ack[i] && ($urandom % 3) == 0) ack[i] = 1'b1;
         end
      end
      wr_en = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule